// File: doc/BRIEF.md
# XTS Key Register Guard

This block keeps the key material for an AES storage cipher that runs in either ECB or XTS mode, and it vets every service request before the cipher is allowed to start. Software writes key words, a per-request configuration word and a data-unit length through a simple word-wide register port. The storage has several slots. Each slot holds a data key and a tweak key of up to 256 bits. The configuration word chooses the slot, the key size, the mode and the direction, and software may change it before any request.

A start strobe asks for a service. One cycle later the block answers with a two-bit code. On acceptance it drives the chosen slot's keys, masked to the configured size, onto an internal key bus. The bus stays valid until the datapath signals completion. Key words can never be read back. Reset clears all storage to zero. While an operation is active, writes aimed at its slot are dropped and a sticky collision flag is raised.

Top module: `xts_key_guard`

## Requirements
- R1: Key sizes of 128 and 256 bits work in both ECB and XTS. With a 128-bit size, bits 255:128 of both key outputs are zero. In ECB mode the tweak output is zero. The key_256, key_xts and key_enc outputs repeat the accepted configuration.
- R2: Register map (word addresses): 0x00 is config, with bit0 = 256-bit size, bit1 = XTS, bit2 = encrypt and bits 9:8 = slot. 0x01 is the data-unit length in AES blocks. 0x02 is status, with bit0 = write collision. Keys live at 0x40 + slot*16 + half*8 + word, where half 0 = data key, half 1 = tweak key, and word 0 = bits 31:0. A read returns its data one cycle after rd_en. Config and length read back as written. Any key address reads as zero.
- R3: Reset clears every key word, every slot-written mark, the config, the length and the collision flag.
- R4: An XTS start whose data and tweak keys match is rejected with code 1. The comparison covers bits 127:0 for a 128-bit size and all 256 bits for a 256-bit size. ECB starts skip this check.
- R5: An XTS start with a length above 2^20 blocks is rejected with code 2. Exactly 2^20 is allowed. ECB starts skip this check.
- R6: The slot field in the config word picks the slot whose keys a start uses.
- R7: A start that names a slot with no key write since reset is rejected with code 3. Rejection priority, highest first: code 3, then code 1, then code 2. Code 0 means accepted.
- R8: A start made while idle yields rsp_valid high for exactly the following cycle, with the code.
- R9: After an accepted start, key_vld is high from the response cycle until the cycle after op_done. Whenever key_vld is low, both key buses are zero.
- R10: While an operation is active, a key write to its slot leaves that slot unchanged and sets status bit0. The bit stays set until reset. Writes to other slots still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| start | input | 1 | Service request strobe |
| op_done | input | 1 | Datapath finished the active operation |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 accepted, 1 keys equal, 2 length too long, 3 slot empty |
| key_vld | output | 1 | Key bus valid, operation active |
| key_256 | output | 1 | Active operation uses 256-bit keys |
| key_xts | output | 1 | Active operation is XTS |
| key_enc | output | 1 | Active operation encrypts |
| key_data | output | 256 | Data key of the active slot |
| key_twk | output | 256 | Tweak key of the active slot |

## Verification
The assertions assume that start is never raised while an operation is active. They also assume that op_done comes only while one is active and that no key write lands in the same cycle as a start. The stimulus keeps to this: every start waits until the previous response has been checked and any accepted operation has been closed with op_done. Register writes are issued only in cycles where start is low. The collision case writes during an active operation by design, but never in the start cycle itself.

// File: rtl/xkg_pkg.sv
// Package for the key register guard.
// Holds the fixed key width, the response codes, the register addresses
// and the record types shared by the submodules.
package xkg_pkg;
    localparam int KEY_MAX   = 256;
    localparam int HALF_KEY  = 128;
    localparam int ADDR_CFG  = 0;
    localparam int ADDR_LEN  = 1;
    localparam int ADDR_STAT = 2;

    typedef logic [KEY_MAX-1:0] key_t;

    typedef enum logic [1:0] {
        RSP_OK         = 2'd0,
        RSP_KEYS_EQUAL = 2'd1,
        RSP_LEN_LONG   = 2'd2,
        RSP_SLOT_EMPTY = 2'd3
    } rsp_e;

    typedef struct packed {
        logic key256;
        logic xts;
        logic enc;
    } mode_t;

    typedef struct packed {
        key_t dat;
        key_t twk;
    } key_pair_t;
endpackage

// File: rtl/xkg_key_store.sv
// Write-only key slot storage.
// Decodes key-range writes, keeps a written mark per slot and blocks
// writes into the slot of an active operation, setting a sticky flag.
// Assumes WORD_W divides 256 and is below 256, and that the key range
// fits in the address space.
module xkg_key_store
    import xkg_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int KEY_BASE  = 'h40,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic                         act,
    input  logic [SLOT_W-1:0]            act_slot,
    output key_pair_t [NUM_SLOTS-1:0]    slots,
    output logic [NUM_SLOTS-1:0]         written,
    output logic                         collide
);
    localparam int KEY_WORDS = KEY_MAX / WORD_W;
    localparam int WORD_BITS = $clog2(KEY_WORDS);
    localparam int SPAN      = NUM_SLOTS * 2 * KEY_WORDS;

    key_pair_t             mem [NUM_SLOTS];
    logic [ADDR_W-1:0]     off;
    logic                  hit;
    logic                  blocked;
    logic [WORD_BITS-1:0]  w_word;
    logic                  w_twk;
    logic [SLOT_W-1:0]     w_slot;

    // Split a write address into slot, key half and word.
    always_comb begin
        off     = wr_addr - ADDR_W'(KEY_BASE);
        hit     = wr_en && (wr_addr >= ADDR_W'(KEY_BASE)) && (off < ADDR_W'(SPAN));
        w_word  = off[WORD_BITS-1:0];
        w_twk   = off[WORD_BITS];
        w_slot  = off[WORD_BITS+1 +: SLOT_W];
        blocked = act && (w_slot == act_slot);
    end

    // Store key words, track written slots, zero everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) mem[s] <= '0;
            written <= '0;
        end else if (hit && !blocked) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (w_slot == SLOT_W'(s)) begin
                    if (w_twk) mem[s].twk[int'(w_word)*WORD_W +: WORD_W] <= wr_data;
                    else       mem[s].dat[int'(w_word)*WORD_W +: WORD_W] <= wr_data;
                    written[s] <= 1'b1;
                end
            end
        end
    end

    // Sticky flag for writes dropped because their slot is in use.
    always_ff @(posedge clk) begin
        if (!rst_n)              collide <= 1'b0;
        else if (hit && blocked) collide <= 1'b1;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
        assign slots[g] = mem[g];
    end

    // R10
    blocked_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && blocked |=> collide);
    // R10
    collide_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> collide);
endmodule

// File: rtl/xkg_cfg_regs.sv
// Configuration, length and status registers with the read port.
// Key addresses read as zero. Reads are registered (one cycle latency).
module xkg_cfg_regs
    import xkg_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int KEY_BASE  = 'h40,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 collide,
    output mode_t                mode,
    output logic [SLOT_W-1:0]    slot,
    output logic [WORD_W-1:0]    du_len,
    output logic [WORD_W-1:0]    rd_data
);
    logic [WORD_W-1:0] rd_mux;

    // Select read data; key space and unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        if (rd_addr == ADDR_W'(ADDR_CFG)) begin
            rd_mux[0]           = mode.key256;
            rd_mux[1]           = mode.xts;
            rd_mux[2]           = mode.enc;
            rd_mux[8 +: SLOT_W] = slot;
        end else if (rd_addr == ADDR_W'(ADDR_LEN)) begin
            rd_mux = du_len;
        end else if (rd_addr == ADDR_W'(ADDR_STAT)) begin
            rd_mux[0] = collide;
        end
    end

    // Capture config and length writes, register read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= '0;
            slot    <= '0;
            du_len  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(ADDR_CFG)) begin
                mode.key256 <= wr_data[0];
                mode.xts    <= wr_data[1];
                mode.enc    <= wr_data[2];
                slot        <= wr_data[8 +: SLOT_W];
            end
            if (wr_en && wr_addr == ADDR_W'(ADDR_LEN)) du_len <= wr_data;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    // R2
    key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_addr >= ADDR_W'(KEY_BASE)) |=> rd_data == '0);
endmodule

// File: rtl/xkg_start_check.sv
// Start-request validation and the active-operation register.
// Checks slot use, key equality over the configured size and the
// data-unit length, answers one cycle after start, and latches the
// accepted configuration until op_done.
// Assumes start is not raised while an operation is active.
module xkg_start_check
    import xkg_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int WORD_W      = 32,
    parameter int MAX_DU_LOG2 = 20,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op_done,
    input  mode_t               mode,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [WORD_W-1:0]   du_len,
    input  logic                slot_written,
    input  key_pair_t           pair,
    output logic                rsp_valid,
    output rsp_e                rsp_code,
    output logic                act,
    output mode_t               act_mode,
    output logic [SLOT_W-1:0]   act_slot
);
    localparam logic [WORD_W-1:0] DU_LIMIT = WORD_W'(1) << MAX_DU_LOG2;

    logic keys_eq;
    logic too_long;
    rsp_e verdict;

    // Work out the verdict in priority order: empty, equal, length.
    always_comb begin
        keys_eq  = mode.key256 ? (pair.dat == pair.twk)
                               : (pair.dat[HALF_KEY-1:0] == pair.twk[HALF_KEY-1:0]);
        too_long = du_len > DU_LIMIT;
        if (!slot_written)            verdict = RSP_SLOT_EMPTY;
        else if (mode.xts && keys_eq) verdict = RSP_KEYS_EQUAL;
        else if (mode.xts && too_long) verdict = RSP_LEN_LONG;
        else                          verdict = RSP_OK;
    end

    // Issue the response one cycle after an idle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
        end else begin
            rsp_valid <= start && !act;
            if (start && !act) rsp_code <= verdict;
        end
    end

    // Hold the accepted configuration until the datapath completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            act_mode <= '0;
            act_slot <= '0;
        end else if (start && !act && verdict == RSP_OK) begin
            act      <= 1'b1;
            act_mode <= mode;
            act_slot <= slot;
        end else if (op_done) begin
            act <= 1'b0;
        end
    end

    // R8
    rsp_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !act |=> rsp_valid);
    // R9
    accept_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code == RSP_OK |-> act);
    // R9
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code != RSP_OK |-> !act);
    // R6
    slot_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && !op_done |=> $stable(act_slot));
endmodule

// File: rtl/xts_key_guard.sv
// Top of the key register guard.
// Wires the register file, the key store and the start checker, and
// drives the masked key bus for the active operation.
module xts_key_guard
    import xkg_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int WORD_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int KEY_BASE    = 'h40,
    parameter int MAX_DU_LOG2 = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    input  logic                 start,
    input  logic                 op_done,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic                 key_vld,
    output logic                 key_256,
    output logic                 key_xts,
    output logic                 key_enc,
    output logic [KEY_MAX-1:0]   key_data,
    output logic [KEY_MAX-1:0]   key_twk
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    key_pair_t [NUM_SLOTS-1:0] slots;
    logic [NUM_SLOTS-1:0]      written;
    logic                      collide;
    mode_t                     mode, act_mode;
    logic [SLOT_W-1:0]         slot, act_slot;
    logic [WORD_W-1:0]         du_len;
    logic                      act;
    rsp_e                      code;
    key_pair_t                 cur;
    key_t                      size_mask;

    xkg_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
                   .KEY_BASE(KEY_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .collide(collide), .mode(mode), .slot(slot), .du_len(du_len),
        .rd_data(rd_data));

    xkg_key_store #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
                    .KEY_BASE(KEY_BASE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .act(act), .act_slot(act_slot),
        .slots(slots), .written(written), .collide(collide));

    xkg_start_check #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W),
                      .MAX_DU_LOG2(MAX_DU_LOG2)) u_chk (
        .clk(clk), .rst_n(rst_n), .start(start), .op_done(op_done),
        .mode(mode), .slot(slot), .du_len(du_len),
        .slot_written(written[slot]), .pair(slots[slot]),
        .rsp_valid(rsp_valid), .rsp_code(code), .act(act),
        .act_mode(act_mode), .act_slot(act_slot));

    // Mask the active slot's keys to the accepted size and mode.
    always_comb begin
        cur       = slots[act_slot];
        size_mask = act_mode.key256 ? '1 : {{HALF_KEY{1'b0}}, {HALF_KEY{1'b1}}};
        key_data  = act ? (cur.dat & size_mask) : '0;
        key_twk   = (act && act_mode.xts) ? (cur.twk & size_mask) : '0;
        key_vld   = act;
        key_256   = act && act_mode.key256;
        key_xts   = act && act_mode.xts;
        key_enc   = act && act_mode.enc;
        rsp_code  = code;
    end

    // R7
    active_slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld |-> written[act_slot]);
    // R9
    bus_opens_on_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_vld) |-> rsp_valid && rsp_code == 2'd0);
endmodule

// File: tb/sim_xts_key_guard.sv
module sim_xts_key_guard;
    localparam int CLK_P = 10;
    localparam logic [31:0] LIM = 32'h0010_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0, start = 1'b0, op_done = 1'b0;
    logic [7:0]   wr_addr = '0, rd_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic         rsp_valid, key_vld, key_256, key_xts, key_enc;
    logic [1:0]   rsp_code;
    logic [255:0] key_data, key_twk;

    int checks = 0;
    int fails  = 0;

    xts_key_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .start(start), .op_done(op_done),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .key_vld(key_vld),
        .key_256(key_256), .key_xts(key_xts), .key_enc(key_enc),
        .key_data(key_data), .key_twk(key_twk));

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [1:0]  slot;
        logic        k256;
        logic        xts;
        logic [31:0] len;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b1, 32'd16,      2'd0},
        '{2'd0, 1'b0, 1'b1, LIM,         2'd0},
        '{2'd0, 1'b1, 1'b1, LIM + 32'd1, 2'd2},
        '{2'd1, 1'b0, 1'b1, 32'd8,       2'd1},
        '{2'd1, 1'b1, 1'b1, 32'd8,       2'd0},
        '{2'd2, 1'b1, 1'b1, 32'd8,       2'd1},
        '{2'd2, 1'b0, 1'b0, 32'd8,       2'd0},
        '{2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 2'd0},
        '{2'd3, 1'b1, 1'b1, 32'd8,       2'd3},
        '{2'd3, 1'b0, 1'b0, 32'd8,       2'd3},
        '{2'd2, 1'b1, 1'b1, LIM + 32'd5, 2'd1},
        '{2'd3, 1'b1, 1'b1, LIM + 32'd5, 2'd3}
    };

    function automatic logic [31:0] pat(int s, bit twk, int w);
        if (twk && (s == 2 || (s == 1 && w < 4))) twk = 1'b0;
        return (twk ? 32'h7000_0000 : 32'hD000_0000) | 32'(s << 8) | 32'(w);
    endfunction

    function automatic logic [255:0] expk(int s, bit twk, bit k256);
        logic [255:0] v = '0;
        for (int w = 0; w < 8; w++)
            if (k256 || w < 4) v[w*32 +: 32] = pat(s, twk, w);
        return v;
    endfunction

    function automatic logic [31:0] cfgw(int s, bit k256, bit xts, bit enc);
        return 32'(s << 8) | {29'd0, enc, xts, k256};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        rd_en = 1'b1; rd_addr = a;
        tick();
        rd_en = 1'b0;
        chk(req, 256'(rd_data), 256'(exp));
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic finish_op();
        op_done = 1'b1;
        tick();
        op_done = 1'b0;
    endtask

    task automatic run_vec(vec_t v);
        string tag;
        case (v.exp)
            2'd1: tag = "R4";
            2'd2: tag = "R5";
            2'd3: tag = "R7";
            default: tag = "R8";
        endcase
        wr(8'h00, cfgw(v.slot, v.k256, v.xts, 1'b1));
        wr(8'h01, v.len);
        pulse_start();
        chk("R8 rsp_valid", 256'(rsp_valid), 256'(1));
        chk(tag, 256'(rsp_code), 256'(v.exp));
        if (v.exp == 2'd0) begin
            chk("R9 key_vld", 256'(key_vld), 256'(1));
            chk("R6 key_data", key_data, expk(v.slot, 1'b0, v.k256));
            chk("R1 key_twk", key_twk, v.xts ? expk(v.slot, 1'b1, v.k256) : '0);
            chk("R1 flags", 256'({key_256, key_xts, key_enc}), 256'({v.k256, v.xts, 1'b1}));
            finish_op();
            chk("R9 closed", 256'({key_vld, |key_data, |key_twk}), 256'(0));
        end else begin
            chk("R9 no key on reject", 256'({key_vld, |key_data}), 256'(0));
            tick();
        end
        chk("R8 single pulse", 256'(rsp_valid), 256'(0));
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R3: reset state
        chk("R3 rsp after reset", 256'({rsp_valid, key_vld, |key_data}), 256'(0));
        rd_chk("R3 status after reset", 8'h02, 32'd0);

        for (int s = 0; s < 3; s++)
            for (int h = 0; h < 2; h++)
                for (int w = 0; w < 8; w++)
                    wr(8'(32'h40 + s*16 + h*8 + w), pat(s, h[0], w));

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: read-back rules
        wr(8'h00, cfgw(2, 1'b1, 1'b1, 1'b1));
        wr(8'h01, 32'h0000_1234);
        rd_chk("R2 cfg read", 8'h00, 32'h0000_0207);
        rd_chk("R2 len read", 8'h01, 32'h0000_1234);
        rd_chk("R2 key read", 8'h40, 32'd0);
        rd_chk("R2 tweak read", 8'h5F, 32'd0);

        // R10: collision on the active slot
        wr(8'h00, cfgw(0, 1'b1, 1'b1, 1'b0));
        wr(8'h01, 32'd16);
        pulse_start();
        chk("R10 accept", 256'(rsp_code), 256'(0));
        wr(8'h40, 32'hBAD0_0000);
        wr(8'h70, 32'h3333_0000);
        rd_chk("R10 status set", 8'h02, 32'd1);
        chk("R10 key kept", 256'(key_data[31:0]), 256'(pat(0, 1'b0, 0)));
        chk("R1 decrypt flag", 256'(key_enc), 256'(0));
        finish_op();
        rd_chk("R10 status sticky", 8'h02, 32'd1);
        wr(8'h00, cfgw(3, 1'b0, 1'b0, 1'b1));
        pulse_start();
        chk("R10 other slot written", 256'(rsp_code), 256'(0));
        chk("R7 slot3 key", key_data, 256'(32'h3333_0000));
        finish_op();

        // R3: reset zeroes keys and flags
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        rd_chk("R3 status cleared", 8'h02, 32'd0);
        rd_chk("R3 cfg cleared", 8'h00, 32'd0);
        pulse_start();
        chk("R3 slot empty after reset", 256'(rsp_code), 256'(3));
        chk("R3 no key", 256'(key_vld), 256'(0));

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule